// File: doc/BRIEF.md
# Chained Character-Class Pattern Matcher

This block matches a fixed regular expression against a byte stream, one byte per clock. The expression is spread over an array of recognizer cells. Each cell holds a 256-entry membership mask and fires when it is enabled and the current byte falls inside its class. Parameters fix the cell classes, the edges between cells, the cells that may begin a match, the cells that repeat (Kleene star) and the cells whose firing counts as a full match.

A byte offered with `valid_i` high reaches every cell in the same cycle. A cell is enabled in three ways. It may be a start cell. It may have been armed by an upstream cell that fired on the previous valid byte. It may follow an enabled star cell, because a star cell can match zero times and so passes its enable straight on. That pass-through is combinational, so a chain of star cells hands an enable from its head to its tail within one cycle. Only firings are registered: a firing arms the successor cells, and for a star cell it also re-arms the cell itself, for the next valid byte.

The per-cell firing vector is the match output. A separate accept flag reports a firing of any accepting cell. When no byte is offered, nothing fires and the armed state is kept.

Top module: `rxm_matcher`

## Requirements
- R1: The asynchronous active-low reset clears every armed bit. After reset only start cells can fire. With the default build, bytes `d` (0x64) and `b` (0x62) give `match_o` = 0.
- R2: A cell fires only if the mask bit indexed by the byte value is set. Bit k of `match_o` is cell k. With the default build, `A` (0x41) fires nothing, and after `a` the byte `c` fires cell 1 (`match_o` = 4'b0010).
- R3: A cell that fires on a valid byte arms each successor cell for the next valid byte. With the default build, `a` `b` `x` `d` fires cells 0, 1, 2 and 3 in turn.
- R4: Start cells are enabled on every valid byte, whatever the history. With the default build, `a` `a` and `a` `d` `a` fire cell 0 on each `a`.
- R5: A star cell that fires arms itself for the next valid byte. With the default build, `a` `b` `b` fires cell 1 on both `b`s.
- R6: An enabled star cell enables its successors in the same cycle, through any number of star cells in a row. With the default build, `a` `d` fires cell 3 on the `d`, passing through both star cells.
- R7: While `valid_i` is low, `match_o` and `accept_o` are 0 and the armed state does not change, whatever byte is present.
- R8: `accept_o` is high exactly when a cell in the accepting set fires. In the default build this is cell 3 only.
- R9: An armed bit that is not refreshed by a firing is dropped after the next valid byte. With the default build, `a` `z` `d` and `a` `d` `d` give no firing on the final `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A byte is offered this cycle |
| sym_i | input | 8 | Byte broadcast to all cells |
| match_o | output | N_CELLS | Per-cell firing for the current byte |
| accept_o | output | 1 | Some accepting cell fired |

## Verification
The bench uses the default parameters: four cells that encode `a[bc]*[xy]*d`, with cell 0 as the only start cell, cells 1 and 2 as stars and cell 3 as the accepting cell. With two stars in a row, the zero-repetition path from `a` to `d` needs a combinational enable to cross two cells in one cycle. The same build also covers self re-arming, the mixing of both star classes, start cells re-entering at every position, and armed state being dropped by a byte outside every class. Gaps in `valid_i` placed in the middle of a partial match show that the armed state holds across idle cycles.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int unsigned SYM_W   = 8;
  localparam int unsigned CLASS_W = 1 << SYM_W;

  function automatic logic [CLASS_W-1:0] class_span(int unsigned lo, int unsigned hi);
    logic [CLASS_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < CLASS_W; k++)
      if (k >= lo && k <= hi) m[k] = 1'b1;
    return m;
  endfunction

  // default expression a[bc]*[xy]*d over four cells
  function automatic logic [4*CLASS_W-1:0] demo_classes();
    logic [4*CLASS_W-1:0] m;
    m = '0;
    m[0*CLASS_W +: CLASS_W] = class_span(8'h61, 8'h61);
    m[1*CLASS_W +: CLASS_W] = class_span(8'h62, 8'h63);
    m[2*CLASS_W +: CLASS_W] = class_span(8'h78, 8'h79);
    m[3*CLASS_W +: CLASS_W] = class_span(8'h64, 8'h64);
    return m;
  endfunction
endpackage

// File: rtl/rxm_class_bank.sv
module rxm_class_bank
  import rxm_pkg::*;
#(
  parameter int unsigned               N_CELLS     = 4,
  parameter logic [N_CELLS*CLASS_W-1:0] CLASS_MASKS = '0
) (
  input  logic [SYM_W-1:0]   sym_i,
  output logic [N_CELLS-1:0] hit_o
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam logic [CLASS_W-1:0] CellMask = CLASS_MASKS[i*CLASS_W +: CLASS_W];
    assign hit_o[i] = CellMask[sym_i];
  end
endmodule

// File: rtl/rxm_enable_net.sv
module rxm_enable_net #(
  parameter int unsigned               N_CELLS    = 4,
  parameter logic [N_CELLS*N_CELLS-1:0] PRED_MASKS = '0,
  parameter logic [N_CELLS-1:0]         START_MASK = '0,
  parameter logic [N_CELLS-1:0]         STAR_MASK  = '0
) (
  input  logic               valid_i,
  input  logic [N_CELLS-1:0] hit_i,
  input  logic [N_CELLS-1:0] arm_i,
  output logic [N_CELLS-1:0] en_o,
  output logic [N_CELLS-1:0] act_o
);
  logic [N_CELLS-1:0] en_v;

  // cells in index order; only lower-index predecessors count, keeping the net acyclic
  always_comb begin
    en_v = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      en_v[i] = START_MASK[i] | arm_i[i];
      for (int j = 0; j < i; j++)
        en_v[i] = en_v[i] | (PRED_MASKS[i*N_CELLS+j] & STAR_MASK[j] & en_v[j]);
    end
  end

  assign en_o  = en_v;
  assign act_o = en_v & hit_i & {N_CELLS{valid_i}};
endmodule

// File: rtl/rxm_state_regs.sv
module rxm_state_regs #(
  parameter int unsigned               N_CELLS    = 4,
  parameter logic [N_CELLS*N_CELLS-1:0] PRED_MASKS = '0,
  parameter logic [N_CELLS-1:0]         STAR_MASK  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_CELLS-1:0] act_i,
  output logic [N_CELLS-1:0] arm_o
);
  logic [N_CELLS-1:0] arm_d, arm_q;

  always_comb begin
    arm_d = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      arm_d[i] = STAR_MASK[i] & act_i[i];
      for (int j = 0; j < i; j++)
        arm_d[i] = arm_d[i] | (PRED_MASKS[i*N_CELLS+j] & act_i[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arm_q <= '0;
    else if (valid_i) arm_q <= arm_d;
  end

  assign arm_o = arm_q;
endmodule

// File: rtl/rxm_matcher.sv
module rxm_matcher
  import rxm_pkg::*;
#(
  parameter int unsigned               N_CELLS     = 4,
  parameter logic [N_CELLS*CLASS_W-1:0] CLASS_MASKS = demo_classes(),
  // bit i*N_CELLS+j set: cell j feeds cell i (j < i)
  parameter logic [N_CELLS*N_CELLS-1:0] PRED_MASKS  = 16'h4210,
  parameter logic [N_CELLS-1:0]         START_MASK  = 4'b0001,
  parameter logic [N_CELLS-1:0]         STAR_MASK   = 4'b0110,
  parameter logic [N_CELLS-1:0]         ACCEPT_MASK = 4'b1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [SYM_W-1:0]   sym_i,
  output logic [N_CELLS-1:0] match_o,
  output logic               accept_o
);
  logic [N_CELLS-1:0] hit, en, act, arm_q;

  rxm_class_bank #(
    .N_CELLS    (N_CELLS),
    .CLASS_MASKS(CLASS_MASKS)
  ) u_class (
    .sym_i(sym_i),
    .hit_o(hit)
  );

  rxm_enable_net #(
    .N_CELLS   (N_CELLS),
    .PRED_MASKS(PRED_MASKS),
    .START_MASK(START_MASK),
    .STAR_MASK (STAR_MASK)
  ) u_enable (
    .valid_i(valid_i),
    .hit_i  (hit),
    .arm_i  (arm_q),
    .en_o   (en),
    .act_o  (act)
  );

  rxm_state_regs #(
    .N_CELLS   (N_CELLS),
    .PRED_MASKS(PRED_MASKS),
    .STAR_MASK (STAR_MASK)
  ) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .act_i  (act),
    .arm_o  (arm_q)
  );

  assign match_o  = act;
  assign accept_o = |(act & ACCEPT_MASK);
endmodule

// File: rtl/rxm_matcher_sva.sv
module rxm_matcher_sva
  import rxm_pkg::*;
#(
  parameter int unsigned               N_CELLS     = 4,
  parameter logic [N_CELLS*CLASS_W-1:0] CLASS_MASKS = '0,
  parameter logic [N_CELLS*N_CELLS-1:0] PRED_MASKS  = '0,
  parameter logic [N_CELLS-1:0]         START_MASK  = '0,
  parameter logic [N_CELLS-1:0]         STAR_MASK   = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [SYM_W-1:0]   sym_i,
  input logic [N_CELLS-1:0] match_o,
  input logic               accept_o,
  input logic [N_CELLS-1:0] arm_q
);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (match_o == '0 && !accept_o));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(arm_q));

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam logic [CLASS_W-1:0] CellMask = CLASS_MASKS[i*CLASS_W +: CLASS_W];

    p_in_class_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[i] |-> CellMask[sym_i]);

    if (START_MASK[i]) begin : g_start
      p_start_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && CellMask[sym_i]) |-> match_o[i]);
    end

    if (STAR_MASK[i]) begin : g_star
      p_self_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && match_o[i]) |=> arm_q[i]);
    end

    for (genvar j = 0; j < i; j++) begin : g_pred
      if (PRED_MASKS[i*N_CELLS+j]) begin : g_edge
        p_arm_succ_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (valid_i && match_o[j]) |=> arm_q[i]);
      end
    end
  end
endmodule

bind rxm_matcher rxm_matcher_sva #(
  .N_CELLS    (N_CELLS),
  .CLASS_MASKS(CLASS_MASKS),
  .PRED_MASKS (PRED_MASKS),
  .START_MASK (START_MASK),
  .STAR_MASK  (STAR_MASK)
) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sym_i   (sym_i),
  .match_o (match_o),
  .accept_o(accept_o),
  .arm_q   (arm_q)
);

// File: tb/tb_rxm_matcher.sv
`timescale 1ns/1ps
module tb_rxm_matcher;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] sym_i = 8'h00;
  logic [3:0] match_o;
  logic       accept_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  rxm_matcher dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sym_i   (sym_i),
    .match_o (match_o),
    .accept_o(accept_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0; sym_i = 8'h00;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive one byte, check the combinational response before the next edge
  task automatic step(input logic [7:0] ch, input logic vld,
                      input logic [3:0] exp_m, input string req);
    logic exp_a;
    @(negedge clk_i);
    sym_i = ch; valid_i = vld;
    #1;
    exp_a = exp_m[3];
    checks++;
    if (match_o !== exp_m || accept_o !== exp_a) begin
      failures++;
      $display("FAIL %s byte=%h valid=%0b match=%b/%b expected %b/%b",
               req, ch, vld, match_o, accept_o, exp_m, exp_a);
    end
  endtask

  task automatic t_reset_r1();
    do_reset();
    step(8'h64, 1'b0, 4'b0000, "R1 idle after reset");
    step(8'h64, 1'b1, 4'b0000, "R1 d after reset");
    step(8'h62, 1'b1, 4'b0000, "R1 b after reset");
  endtask

  task automatic t_class_r2();
    do_reset();
    step(8'h41, 1'b1, 4'b0000, "R2 A outside class");
    step(8'h61, 1'b1, 4'b0001, "R2 a");
    step(8'h63, 1'b1, 4'b0010, "R2 c in star class");
    step(8'h7a, 1'b1, 4'b0000, "R2 z clears");
    step(8'h61, 1'b1, 4'b0001, "R2 a");
    step(8'h79, 1'b1, 4'b0100, "R2 y in second star class");
  endtask

  task automatic t_chain_r3();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R3 a");
    step(8'h62, 1'b1, 4'b0010, "R3 b");
    step(8'h78, 1'b1, 4'b0100, "R3 x");
    step(8'h64, 1'b1, 4'b1000, "R3 R8 d accepts");
  endtask

  task automatic t_start_r4();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R4 first a");
    step(8'h61, 1'b1, 4'b0001, "R4 second a");
    step(8'h64, 1'b1, 4'b1000, "R4 d");
    step(8'h61, 1'b1, 4'b0001, "R4 a after match");
  endtask

  task automatic t_star_r5();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R5 a");
    step(8'h62, 1'b1, 4'b0010, "R5 b once");
    step(8'h62, 1'b1, 4'b0010, "R5 b again");
    step(8'h79, 1'b1, 4'b0100, "R5 y");
    step(8'h78, 1'b1, 4'b0100, "R5 x repeat");
    step(8'h64, 1'b1, 4'b1000, "R5 d");
  endtask

  task automatic t_ripple_r6();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R6 a");
    step(8'h64, 1'b1, 4'b1000, "R6 d through two stars");
    step(8'h61, 1'b1, 4'b0001, "R6 a");
    step(8'h63, 1'b1, 4'b0010, "R6 c");
    step(8'h64, 1'b1, 4'b1000, "R6 d through one star");
  endtask

  task automatic t_idle_r7();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R7 a");
    step(8'h62, 1'b1, 4'b0010, "R7 b");
    step(8'h64, 1'b0, 4'b0000, "R7 idle d");
    step(8'h7a, 1'b0, 4'b0000, "R7 idle z");
    step(8'h61, 1'b0, 4'b0000, "R7 idle a");
    step(8'h62, 1'b1, 4'b0010, "R7 state kept b");
    step(8'h64, 1'b1, 4'b1000, "R7 R8 d accepts");
  endtask

  task automatic t_drop_r9();
    do_reset();
    step(8'h61, 1'b1, 4'b0001, "R9 a");
    step(8'h7a, 1'b1, 4'b0000, "R9 z");
    step(8'h64, 1'b1, 4'b0000, "R9 d after z");
    step(8'h61, 1'b1, 4'b0001, "R9 a");
    step(8'h64, 1'b1, 4'b1000, "R9 d");
    step(8'h64, 1'b1, 4'b0000, "R9 second d");
  endtask

  initial begin
    t_reset_r1();
    t_class_r2();
    t_chain_r3();
    t_start_r4();
    t_star_r5();
    t_ripple_r6();
    t_idle_r7();
    t_drop_r9();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule